// File: doc/BRIEF.md
# Transmit Collision and Statistics Counters

This block keeps the transmit-side statistics of one Ethernet port. It watches the events that the transmit MAC already produces: a frame-complete strobe with its outcome, the number of retransmissions the frame needed, and its length in octets. It also sees each collision with its position in byte times since transmit enable rose, transmit enable and carrier sense, a defer strobe, a FIFO-underrun strobe and the duplex mode. From these it sorts each event into one of nine wrap-around counters.

Collisions are classified in the block. A collision more than one slot (64 byte times) after transmit enable rose is late. A frame that saw any late collision is left out of the single- and multiple-retry counts. A sixteenth collision that is also late lands in both the sixteen-retry and the late-collision counters. In full-duplex mode the collision-related counters and the defer counter are frozen. Successful frames always add one to the frame counter and their length to the octet counter. Counters reset to zero and are read as plain registered outputs.

Top module: `tx_stat_counters`

## Requirements
- R1: When `frm_done` is high with `frm_ok` high and `frm_retries` equal to 1, and the frame saw no late collision and `full_duplex` is low, `cnt_single` increments by one at that clock edge; otherwise it holds.
- R2: A successful frame with `frm_retries` from 2 to 15, no late collision and `full_duplex` low increments `cnt_multi` by one; 0, 1 or 16 retries leave it unchanged.
- R3: When `frm_done` is high with `frm_ok` low and `frm_retries` equal to 16 while `full_duplex` is low, `cnt_sixteen` increments by one; a failed frame with any other retry count changes no counter.
- R4: A `coll_evt` with `coll_pos` greater than 64 is a late collision and increments `cnt_late` when `full_duplex` is low; `coll_pos` of 64 or less does not.
- R5: A late collision anywhere in a frame, including in the same cycle as `frm_done`, stops that frame from counting in `cnt_single` or `cnt_multi`; the marker clears when the frame completes. A late collision in the cycle where a frame is abandoned after 16 retries increments both `cnt_sixteen` and `cnt_late`.
- R6: While `full_duplex` is high, `cnt_single`, `cnt_multi`, `cnt_sixteen`, `cnt_late` and `cnt_defer` do not change.
- R7: `cnt_nocarrier` increments by one at the clock edge where `tx_en` is first seen low after a high period, if `crs` was never high during that period or fell from high to low while `tx_en` stayed high; it increments at most once per period.
- R8: Each cycle with `underrun_evt` high increments `cnt_underrun`, in either duplex mode.
- R9: A frame completing with `frm_ok` high adds one to `cnt_frames` and `frm_len` to `cnt_octets`, in either duplex mode. A failed frame adds nothing.
- R10: Each cycle with `defer_evt` high and `full_duplex` low increments `cnt_defer`.
- R11: Synchronous active-high `rst` clears all counters to zero. Every counter update becomes visible on the clock edge that samples the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | Port runs full duplex |
| frm_done | input | 1 | One-cycle strobe: frame finished |
| frm_ok | input | 1 | Outcome with `frm_done`: 1 sent, 0 abandoned |
| frm_retries | input | RTRY_W (5) | Retransmissions the frame needed |
| frm_len | input | LEN_W (11) | Frame length in octets, preamble excluded, CRC included |
| coll_evt | input | 1 | One-cycle strobe: a collision occurred |
| coll_pos | input | POS_W (11) | Byte times since transmit enable rose, with `coll_evt` |
| tx_en | input | 1 | Transmit enable |
| crs | input | 1 | Carrier sense |
| defer_evt | input | 1 | Transmission deferred due to carrier |
| underrun_evt | input | 1 | Transmit FIFO emptied before end of frame |
| cnt_single | output | CNT_W (32) | Single-retry count |
| cnt_multi | output | CNT_W (32) | Multiple-retry count |
| cnt_sixteen | output | CNT_W (32) | Abandoned after sixteen collisions |
| cnt_late | output | CNT_W (32) | Late collisions |
| cnt_nocarrier | output | CNT_W (32) | Loss-of-carrier count |
| cnt_defer | output | CNT_W (32) | Deferred transmissions |
| cnt_underrun | output | CNT_W (32) | FIFO underruns |
| cnt_frames | output | CNT_W (32) | Frames sent successfully |
| cnt_octets | output | CNT_W (32) | Octets sent in successful frames |

## Verification
Retry counts of 0, 1, 2, 15 and 16 are tried with both outcomes, which separates the single, multiple and sixteen buckets at their edges and shows that failures add no octets. Collisions at positions 64 and 65 set the late boundary. A late collision early in a frame, another in the same cycle as completion, and a following clean frame show that the exclusion applies per frame and is cleared afterwards, and that the double count happens on an abandoned frame. The same mix under full duplex shows which counters freeze and which keep running. Transmit bursts with carrier absent, present throughout, dropping once, dropping twice, and rising late tell the per-burst loss-of-carrier rule apart from counting every edge.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;

  // Counter slots; the order is the layout of the counter bank.
  typedef enum int unsigned {
    CI_SINGLE    = 0,
    CI_MULTI     = 1,
    CI_SIXTEEN   = 2,
    CI_LATE      = 3,
    CI_NOCARRIER = 4,
    CI_DEFER     = 5,
    CI_UNDERRUN  = 6,
    CI_FRAMES    = 7,
    CI_OCTETS    = 8
  } cnt_id_e;

  localparam int unsigned NUM_CNT = 9;

  // Collision window in byte times: beyond this a collision is late.
  localparam int unsigned SLOT_BYTES_DEF = 64;
  // Attempt limit: a frame is abandoned after this many collisions.
  localparam int unsigned MAX_ATTEMPTS_DEF = 16;

endpackage

// File: rtl/txs_late_tracker.sv
module txs_late_tracker #(
  parameter int unsigned POS_W      = 11,
  parameter int unsigned SLOT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coll_evt,
  input  logic [POS_W-1:0] coll_pos,
  input  logic             frm_done,
  output logic             late_now,
  output logic             late_in_frame
);

  localparam logic [POS_W-1:0] SLOT_LIM = POS_W'(SLOT_BYTES);

  logic late_seen_q;

  assign late_now      = coll_evt && (coll_pos > SLOT_LIM);
  // Includes a late collision arriving with the completion strobe.
  assign late_in_frame = late_seen_q || late_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      late_seen_q <= 1'b0;
    end else if (frm_done) begin
      late_seen_q <= 1'b0;
    end else if (late_now) begin
      late_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/txs_carrier_mon.sv
module txs_carrier_mon (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic crs,
  output logic loss_pulse
);

  logic txen_q;
  logic crs_q;
  logic seen_q;
  logic fell_q;
  logic burst_end;

  assign burst_end  = txen_q && !tx_en;
  // One verdict per transmit burst, taken when it ends.
  assign loss_pulse = burst_end && (!seen_q || fell_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_q <= 1'b0;
      crs_q  <= 1'b0;
      seen_q <= 1'b0;
      fell_q <= 1'b0;
    end else begin
      txen_q <= tx_en;
      crs_q  <= crs;
      if (tx_en && !txen_q) begin
        seen_q <= crs;
        fell_q <= 1'b0;
      end else if (tx_en) begin
        seen_q <= seen_q || crs;
        fell_q <= fell_q || (crs_q && !crs);
      end
    end
  end

endmodule

// File: rtl/txs_event_classifier.sv
module txs_event_classifier
  import tx_stat_pkg::*;
#(
  parameter int unsigned RTRY_W       = 5,
  parameter int unsigned MAX_ATTEMPTS = 16
) (
  input  logic              full_duplex,
  input  logic              frm_done,
  input  logic              frm_ok,
  input  logic [RTRY_W-1:0] frm_retries,
  input  logic              late_now,
  input  logic              late_in_frame,
  input  logic              loss_pulse,
  input  logic              defer_evt,
  input  logic              underrun_evt,
  output logic [NUM_CNT-1:0] inc_vec
);

  localparam logic [RTRY_W-1:0] RT_ONE = RTRY_W'(1);
  localparam logic [RTRY_W-1:0] RT_MAX = RTRY_W'(MAX_ATTEMPTS);

  logic sent;
  logic abandoned;
  logic hd;

  assign sent      = frm_done && frm_ok;
  assign abandoned = frm_done && !frm_ok;
  assign hd        = !full_duplex;

  always_comb begin
    inc_vec               = '0;
    inc_vec[CI_SINGLE]    = hd && sent && !late_in_frame && (frm_retries == RT_ONE);
    inc_vec[CI_MULTI]     = hd && sent && !late_in_frame &&
                            (frm_retries > RT_ONE) && (frm_retries < RT_MAX);
    inc_vec[CI_SIXTEEN]   = hd && abandoned && (frm_retries == RT_MAX);
    inc_vec[CI_LATE]      = hd && late_now;
    inc_vec[CI_NOCARRIER] = loss_pulse;
    inc_vec[CI_DEFER]     = hd && defer_evt;
    inc_vec[CI_UNDERRUN]  = underrun_evt;
    inc_vec[CI_FRAMES]    = sent;
    inc_vec[CI_OCTETS]    = sent;
  end

endmodule

// File: rtl/txs_counter.sv
module txs_counter #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= q + W'(amt);
    end
  end

endmodule

// File: rtl/tx_stat_counters.sv
module tx_stat_counters
  import tx_stat_pkg::*;
#(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned LEN_W        = 11,
  parameter int unsigned RTRY_W       = 5,
  parameter int unsigned POS_W        = 11,
  parameter int unsigned SLOT_BYTES   = SLOT_BYTES_DEF,
  parameter int unsigned MAX_ATTEMPTS = MAX_ATTEMPTS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_duplex,
  input  logic              frm_done,
  input  logic              frm_ok,
  input  logic [RTRY_W-1:0] frm_retries,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              coll_evt,
  input  logic [POS_W-1:0]  coll_pos,
  input  logic              tx_en,
  input  logic              crs,
  input  logic              defer_evt,
  input  logic              underrun_evt,
  output logic [CNT_W-1:0]  cnt_single,
  output logic [CNT_W-1:0]  cnt_multi,
  output logic [CNT_W-1:0]  cnt_sixteen,
  output logic [CNT_W-1:0]  cnt_late,
  output logic [CNT_W-1:0]  cnt_nocarrier,
  output logic [CNT_W-1:0]  cnt_defer,
  output logic [CNT_W-1:0]  cnt_underrun,
  output logic [CNT_W-1:0]  cnt_frames,
  output logic [CNT_W-1:0]  cnt_octets
);

  logic               late_now;
  logic               late_in_frame;
  logic               loss_pulse;
  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   bank_q [NUM_CNT];

  txs_late_tracker #(
    .POS_W      (POS_W),
    .SLOT_BYTES (SLOT_BYTES)
  ) u_late (
    .clk           (clk),
    .rst           (rst),
    .coll_evt      (coll_evt),
    .coll_pos      (coll_pos),
    .frm_done      (frm_done),
    .late_now      (late_now),
    .late_in_frame (late_in_frame)
  );

  txs_carrier_mon u_crs (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .crs        (crs),
    .loss_pulse (loss_pulse)
  );

  txs_event_classifier #(
    .RTRY_W       (RTRY_W),
    .MAX_ATTEMPTS (MAX_ATTEMPTS)
  ) u_cls (
    .full_duplex   (full_duplex),
    .frm_done      (frm_done),
    .frm_ok        (frm_ok),
    .frm_retries   (frm_retries),
    .late_now      (late_now),
    .late_in_frame (late_in_frame),
    .loss_pulse    (loss_pulse),
    .defer_evt     (defer_evt),
    .underrun_evt  (underrun_evt),
    .inc_vec       (inc_vec)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [LEN_W-1:0] step;
    if (i == CI_OCTETS) begin : g_bytes
      assign step = frm_len;
    end else begin : g_unit
      assign step = LEN_W'(1);
    end
    txs_counter #(
      .W     (CNT_W),
      .AMT_W (LEN_W)
    ) u_c (
      .clk (clk),
      .rst (rst),
      .en  (inc_vec[i]),
      .amt (step),
      .q   (bank_q[i])
    );
  end

  assign cnt_single    = bank_q[CI_SINGLE];
  assign cnt_multi     = bank_q[CI_MULTI];
  assign cnt_sixteen   = bank_q[CI_SIXTEEN];
  assign cnt_late      = bank_q[CI_LATE];
  assign cnt_nocarrier = bank_q[CI_NOCARRIER];
  assign cnt_defer     = bank_q[CI_DEFER];
  assign cnt_underrun  = bank_q[CI_UNDERRUN];
  assign cnt_frames    = bank_q[CI_FRAMES];
  assign cnt_octets    = bank_q[CI_OCTETS];

endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned LEN_W        = 11,
  parameter int unsigned RTRY_W       = 5,
  parameter int unsigned POS_W        = 11,
  parameter int unsigned SLOT_BYTES   = 64,
  parameter int unsigned MAX_ATTEMPTS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              full_duplex,
  input logic              frm_done,
  input logic              frm_ok,
  input logic [RTRY_W-1:0] frm_retries,
  input logic [LEN_W-1:0]  frm_len,
  input logic              coll_evt,
  input logic [POS_W-1:0]  coll_pos,
  input logic              defer_evt,
  input logic              underrun_evt,
  input logic [CNT_W-1:0]  cnt_single,
  input logic [CNT_W-1:0]  cnt_multi,
  input logic [CNT_W-1:0]  cnt_sixteen,
  input logic [CNT_W-1:0]  cnt_late,
  input logic [CNT_W-1:0]  cnt_defer,
  input logic [CNT_W-1:0]  cnt_underrun,
  input logic [CNT_W-1:0]  cnt_frames,
  input logic [CNT_W-1:0]  cnt_octets
);

  localparam logic [POS_W-1:0]  SLOT_LIM = POS_W'(SLOT_BYTES);
  localparam logic [RTRY_W-1:0] RT_MAX   = RTRY_W'(MAX_ATTEMPTS);

  p_single_gate_r1: assert property (@(posedge clk) disable iff (rst)
    !(frm_done && frm_ok && frm_retries == RTRY_W'(1)) |=> $stable(cnt_single));

  p_sixteen_step_r3: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !frm_ok && frm_retries == RT_MAX && !full_duplex)
    |=> cnt_sixteen == $past(cnt_sixteen) + CNT_W'(1));

  p_late_step_r4: assert property (@(posedge clk) disable iff (rst)
    (coll_evt && coll_pos > SLOT_LIM && !full_duplex)
    |=> cnt_late == $past(cnt_late) + CNT_W'(1));

  p_late_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(coll_evt && coll_pos > SLOT_LIM) |=> $stable(cnt_late));

  // R6: duplex mode freezes the collision and defer counters
  p_fd_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    full_duplex |=> ($stable(cnt_single) && $stable(cnt_multi) &&
                     $stable(cnt_sixteen) && $stable(cnt_late) &&
                     $stable(cnt_defer)));

  p_underrun_step_r8: assert property (@(posedge clk) disable iff (rst)
    underrun_evt |=> cnt_underrun == $past(cnt_underrun) + CNT_W'(1));

  p_octets_add_r9: assert property (@(posedge clk) disable iff (rst)
    (frm_done && frm_ok) |=> cnt_octets == $past(cnt_octets) + CNT_W'($past(frm_len)));

  p_frames_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(frm_done && frm_ok) |=> ($stable(cnt_frames) && $stable(cnt_octets)));

  p_defer_step_r10: assert property (@(posedge clk) disable iff (rst)
    (defer_evt && !full_duplex) |=> cnt_defer == $past(cnt_defer) + CNT_W'(1));

  // R11: reset clears the bank
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (cnt_single == '0 && cnt_late == '0 && cnt_frames == '0 && cnt_octets == '0));

endmodule

bind tx_stat_counters txs_checker #(
  .CNT_W        (CNT_W),
  .LEN_W        (LEN_W),
  .RTRY_W       (RTRY_W),
  .POS_W        (POS_W),
  .SLOT_BYTES   (SLOT_BYTES),
  .MAX_ATTEMPTS (MAX_ATTEMPTS)
) u_chk (.*);

// File: tb/tx_stat_counters_test.sv
`timescale 1ns/1ps
module tx_stat_counters_test;

  localparam int NC = 9;
  typedef logic [NC-1:0][31:0] snap_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        full_duplex = 0, frm_done = 0, frm_ok = 0;
  logic [4:0]  frm_retries = '0;
  logic [10:0] frm_len = '0;
  logic        coll_evt = 0;
  logic [10:0] coll_pos = '0;
  logic        tx_en = 0, crs = 0, defer_evt = 0, underrun_evt = 0;
  logic [31:0] c_single, c_multi, c_sixteen, c_late, c_nocar,
               c_defer, c_underrun, c_frames, c_octets;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  snap_t exp_q[$];
  snap_t m;           // model counters
  bit    m_late = 0;
  bit    m_txq = 0, m_crsq = 0, m_seen = 0, m_fell = 0;

  always #2 clk = ~clk;

  tx_stat_counters uut (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .frm_done(frm_done),
    .frm_ok(frm_ok), .frm_retries(frm_retries), .frm_len(frm_len),
    .coll_evt(coll_evt), .coll_pos(coll_pos), .tx_en(tx_en), .crs(crs),
    .defer_evt(defer_evt), .underrun_evt(underrun_evt),
    .cnt_single(c_single), .cnt_multi(c_multi), .cnt_sixteen(c_sixteen),
    .cnt_late(c_late), .cnt_nocarrier(c_nocar), .cnt_defer(c_defer),
    .cnt_underrun(c_underrun), .cnt_frames(c_frames), .cnt_octets(c_octets)
  );

  function automatic string tag(int i);
    case (i)
      0: return "R1 single";    1: return "R2 multi";
      2: return "R3 sixteen";   3: return "R4 late";
      4: return "R7 nocarrier"; 5: return "R10 defer";
      6: return "R8 underrun";  7: return "R9 frames";
      default: return "R9 octets";
    endcase
  endfunction

  // Driver: one cycle of stimulus plus the expected counters after that edge.
  task automatic step(input bit fd, input bit dn, input bit ok, input int rt,
                      input int len, input bit ce, input int pos,
                      input bit te, input bit cs, input bit df, input bit uf);
    bit late_now, late_frm;
    @(negedge clk);
    full_duplex = fd; frm_done = dn; frm_ok = ok; frm_retries = 5'(rt);
    frm_len = 11'(len); coll_evt = ce; coll_pos = 11'(pos);
    tx_en = te; crs = cs; defer_evt = df; underrun_evt = uf;
    late_now = ce && (pos > 64);
    late_frm = m_late || late_now;
    if (!fd && late_now) m[3]++;
    if (dn && ok) begin
      m[7]++; m[8] += 32'(len);
      if (!fd && !late_frm && rt == 1) m[0]++;
      if (!fd && !late_frm && rt > 1 && rt < 16) m[1]++;
    end
    if (dn && !ok && !fd && rt == 16) m[2]++;
    if (dn) m_late = 0; else if (late_now) m_late = 1;
    if (m_txq && !te && (!m_seen || m_fell)) m[4]++;
    if (te && !m_txq) begin m_seen = cs; m_fell = 0; end
    else if (te) begin m_seen = m_seen || cs; m_fell = m_fell || (m_crsq && !cs); end
    m_txq = te; m_crsq = cs;
    if (!fd && df) m[5]++;
    if (uf) m[6]++;
    exp_q.push_back(m);
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0,0,0); endtask
  task automatic frame(input bit fd, input bit ok, input int rt, input int len);
    step(fd,1,ok,rt,len,0,0,0,0,0,0);
  endtask
  task automatic coll(input bit fd, input int pos);
    step(fd,0,0,0,0,1,pos,0,0,0,0);
  endtask
  task automatic burst(input bit c0, input bit c1, input bit c2, input bit c3);
    step(0,0,0,0,0,0,0,1,c0,0,0); step(0,0,0,0,0,0,0,1,c1,0,0);
    step(0,0,0,0,0,0,0,1,c2,0,0); step(0,0,0,0,0,0,0,1,c3,0,0);
    idle();
  endtask

  // Monitor: compare after each edge that has a pending expectation.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        snap_t e;
        snap_t a;
        e = exp_q.pop_front();
        a = {c_octets, c_frames, c_underrun, c_defer, c_nocar,
             c_late, c_sixteen, c_multi, c_single};
        for (int i = 0; i < NC; i++) begin
          total++;
          if (a[i] !== e[i]) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag(i), a[i], e[i], $time);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle();                          // R11: reset value zero
    frame(0,1,0,64);                 // R9: clean send
    frame(0,1,1,100);                // R1
    frame(0,0,1,100);                // R3/R9: failed, no counts
    frame(0,1,2,200);                // R2 lower edge
    frame(0,1,15,1518);              // R2 upper edge
    frame(0,1,16,300);               // R2: 16 is outside multi
    frame(0,0,16,300);               // R3
    frame(0,0,5,300);                // R3: other failure ignored
    coll(0,64);                      // R4: boundary, not late
    coll(0,65);                      // R4: late
    frame(0,1,1,70);                 // R5: excluded by earlier late
    frame(0,1,1,70);                 // R5: marker cleared, counts
    step(0,1,0,16,0,1,100,0,0,0,0);  // R5: 16th late, both counters
    step(0,1,1,3,80,1,90,0,0,0,0);   // R5: same-cycle late excludes multi
    frame(0,1,2,80);                 // R2 after clear
    frame(1,1,1,60);                 // R6: FD single frozen, R9 still counts
    frame(1,0,16,60);                // R6
    coll(1,200);                     // R6 late frozen
    step(1,0,0,0,0,0,0,0,0,1,1);     // R6 defer frozen, R8 underrun counts
    step(0,0,0,0,0,0,0,0,0,1,0);     // R10
    step(0,0,0,0,0,0,0,0,0,1,1);     // R10, R8
    frame(1,1,2,1000);               // R6 multi frozen, R9 octets
    burst(0,0,0,0);                  // R7: carrier never rose
    burst(1,1,1,1);                  // R7: carrier held, no count
    burst(1,0,0,0);                  // R7: carrier fell
    burst(1,0,1,0);                  // R7: two drops, one count
    burst(0,0,1,1);                  // R7: late rise, no drop, no count
    step(0,0,0,0,0,0,0,1,0,0,0);     // R7: one-cycle burst without carrier
    idle();
    idle();
    repeat (3) @(posedge clk);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule